// File: doc/BRIEF.md
# Dual-Mode Serial Frame Transmitter

This block turns one data byte into a serial bit stream on a single output line. It runs in one of two modes, chosen per character. In asynchronous mode it wraps the character in a start bit and a stop bit. The character is 7 or 8 bits wide, and an even or odd parity bit can follow it. In clocked synchronous mode it always sends exactly 8 data bits with no framing and no parity, and it drives a serial clock output alongside the data.

A host places a byte on `tx_data` and pulses `tx_load` while the transmitter is idle. The mode inputs are captured in that same cycle, so the host may change them at any later time without disturbing the character in flight. Timing comes from an external baud tick. An asynchronous bit lasts 16 ticks. A synchronous bit lasts two ticks: the first makes the clock fall and the second makes it rise. `busy` and `empty` tell the host when another byte can be accepted.

Top module: `sertx_top`

## Requirements
- R1: After reset `txd` = 1, `sclk` = 1, `busy` = 0 and `empty` = 1.
- R2: In asynchronous mode (`sync_mode` = 0) a frame is a start bit (0), then the data bits least significant first, then a stop bit (1). Each bit lasts 16 baud ticks counted after the load cycle, and `txd` changes only in a cycle that follows a tick.
- R3: With `char7` = 1 in asynchronous mode, only data bits 0..6 are sent and bit 7 of `tx_data` never reaches the line. With `char7` = 0, all 8 bits are sent.
- R4: With `par_en` = 1 in asynchronous mode, one parity bit follows the last data bit. With `par_odd` = 0 the data bits and the parity bit together hold an even number of 1s. With `par_odd` = 1 they hold an odd number.
- R5: In synchronous mode (`sync_mode` = 1) exactly 8 data bits are sent least significant first, with no start, stop or parity bit, whatever `char7`, `par_en` and `par_odd` hold.
- R6: `sclk` idles at 1. In synchronous mode, tick 2k+1 of a frame drives `sclk` low and puts data bit k on `txd`. Tick 2k+2 drives `sclk` high again, and `txd` holds its value while `sclk` is low. `sclk` changes only after a tick.
- R7: The mode inputs and `tx_data` are sampled in the load cycle. Changing them later in the frame does not alter the character being sent.
- R8: A `tx_load` pulse while `busy` = 1 is ignored. The current frame goes on unchanged, and no extra frame follows it.
- R9: `busy` rises and `empty` falls in the cycle after an accepted load. Both return (`busy` = 0, `empty` = 1) in the cycle after the tick that ends the final bit.
- R10: While not busy, `txd` and `sclk` both stay at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_mode | input | 1 | 1 = clocked synchronous, 0 = asynchronous |
| char7 | input | 1 | 1 = 7-bit character, 0 = 8-bit (asynchronous only) |
| par_en | input | 1 | 1 = append parity bit (asynchronous only) |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Load strobe, accepted only while idle |
| baud_tick | input | 1 | One-cycle baud timing pulse |
| txd | output | 1 | Serial data line |
| sclk | output | 1 | Serial clock (synchronous mode) |
| busy | output | 1 | A frame is in progress |
| empty | output | 1 | Shift register has sent its last bit |

## Verification
Asynchronous frames are tried with all-zero, all-one and alternating bytes. These show whether the start and stop bits are placed correctly and whether the data goes out least significant bit first. Bytes with bit 7 set are sent in 7-bit mode to show that this bit is dropped. One byte is sent with even parity and then with odd parity, which separates the two parity senses, and a 7-bit frame with parity checks that the parity bit sits in the right place. Synchronous frames are sent with every asynchronous option turned on, to show those options are ignored. Further frames change the mode inputs and pulse load in mid-frame, which shows that configuration is captured at load time and that a load while busy is ignored.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
// Shared types for the dual-mode serial transmitter.
// Assumes: consumers pick their own data width via parameters.
package sertx_pkg;

    // Per-character configuration captured at load time.
    typedef struct packed {
        logic sync;     // 1 = clocked synchronous mode
        logic char7;    // 1 = 7-bit characters (async only)
        logic par_en;   // 1 = parity bit appended (async only)
        logic par_odd;  // 1 = odd parity
    } sertx_cfg_t;

endpackage

// File: rtl/sertx_frame_build.sv
`timescale 1ns/1ps
// Builds the complete bit sequence for one character (bit 0 goes out first)
// together with the number of bits to send.
// Assumes: DW >= 2. Unused upper positions are filled with 1 so that the
// line idles high if they are ever shifted out.
module sertx_frame_build
    import sertx_pkg::*;
#(
    parameter int DW = 8,
    localparam int FW = DW + 3,
    localparam int CW = $clog2(DW + 4)
) (
    input  sertx_cfg_t       cfg,
    input  logic [DW-1:0]    data,
    output logic [FW-1:0]    frame,
    output logic [CW-1:0]    nbits
);

    logic [DW-1:0] masked;
    logic          par_bit;

    // Parity over the bits that are actually sent.
    always_comb begin
        masked = data;
        if (cfg.char7) masked[DW-1] = 1'b0;
        par_bit = (^masked) ^ cfg.par_odd;
    end

    // Frame layout for each mode / length / parity combination.
    always_comb begin
        if (cfg.sync) begin
            frame = {3'b111, data};
            nbits = CW'(DW);
        end else if (!cfg.char7 && !cfg.par_en) begin
            frame = {2'b11, data, 1'b0};
            nbits = CW'(DW + 2);
        end else if (!cfg.char7) begin
            frame = {1'b1, par_bit, data, 1'b0};
            nbits = CW'(DW + 3);
        end else if (!cfg.par_en) begin
            frame = {3'b111, data[DW-2:0], 1'b0};
            nbits = CW'(DW + 1);
        end else begin
            frame = {2'b11, par_bit, data[DW-2:0], 1'b0};
            nbits = CW'(DW + 2);
        end
    end

endmodule

// File: rtl/sertx_bit_timer.sv
`timescale 1ns/1ps
// Counts baud ticks inside a frame and emits the bit-boundary strobes:
// end of an asynchronous bit, and falling / rising edges of the serial clock.
// Assumes: TPB is an even power of two; restart has priority over ticks.
module sertx_bit_timer #(
    parameter int TPB = 16,
    localparam int TW = $clog2(TPB)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic baud_tick,
    output logic bit_end,
    output logic clk_fall,
    output logic clk_rise
);

    logic [TW-1:0] cnt;

    // Tick counter, cleared when a frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (restart)           cnt <= '0;
        else if (run && baud_tick)  cnt <= cnt + TW'(1);
    end

    // Strobes decoded from the counter phase.
    always_comb begin
        bit_end  = run && baud_tick && (cnt == TW'(TPB - 1));
        clk_fall = run && baud_tick && !cnt[0];
        clk_rise = run && baud_tick &&  cnt[0];
    end

endmodule

// File: rtl/sertx_shifter.sv
`timescale 1ns/1ps
// Shift register and frame sequencer. Drives the data line, serial clock
// and the busy / empty flags.
// Assumes: start only arrives while idle; strobes come from sertx_bit_timer.
module sertx_shifter #(
    parameter int DW = 8,
    localparam int FW = DW + 3,
    localparam int CW = $clog2(DW + 4)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          sync_in,
    input  logic [FW-1:0] frame,
    input  logic [CW-1:0] nbits,
    input  logic          bit_end,
    input  logic          clk_fall,
    input  logic          clk_rise,
    output logic          txd,
    output logic          sclk,
    output logic          busy,
    output logic          empty
);

    logic [FW-1:0] sreg;
    logic [CW-1:0] remain;
    logic          sync_q;

    // Frame sequencing: load, shift on bit boundaries, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '1;
            remain <= '0;
            sync_q <= 1'b0;
            busy   <= 1'b0;
            empty  <= 1'b1;
            txd    <= 1'b1;
            sclk   <= 1'b1;
        end else if (start) begin
            busy   <= 1'b1;
            empty  <= 1'b0;
            sync_q <= sync_in;
            sclk   <= 1'b1;
            if (sync_in) begin
                sreg   <= frame;
                remain <= CW'(DW);
                txd    <= 1'b1;
            end else begin
                sreg   <= {1'b1, frame[FW-1:1]};
                remain <= nbits - CW'(1);
                txd    <= frame[0];
            end
        end else if (busy && sync_q) begin
            if (clk_fall) begin
                txd    <= sreg[0];
                sreg   <= {1'b1, sreg[FW-1:1]};
                remain <= remain - CW'(1);
                sclk   <= 1'b0;
            end else if (clk_rise) begin
                sclk <= 1'b1;
                if (remain == '0) begin
                    busy  <= 1'b0;
                    empty <= 1'b1;
                    txd   <= 1'b1;
                end
            end
        end else if (busy && bit_end) begin
            if (remain == '0) begin
                busy  <= 1'b0;
                empty <= 1'b1;
                txd   <= 1'b1;
            end else begin
                txd    <= sreg[0];
                sreg   <= {1'b1, sreg[FW-1:1]};
                remain <= remain - CW'(1);
            end
        end
    end

endmodule

// File: rtl/sertx_top.sv
`timescale 1ns/1ps
// Dual-mode serial frame transmitter: asynchronous (start/data/parity/stop)
// or clocked synchronous (8 bits plus serial clock).
// Assumes: baud_tick is a one-cycle pulse; configuration is taken at load.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16,
    localparam int FRAME_W = DATA_W + 3,
    localparam int CNT_W   = $clog2(DATA_W + 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic              char7,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    input  logic              baud_tick,
    output logic              txd,
    output logic              sclk,
    output logic              busy,
    output logic              empty
);

    sertx_cfg_t         cfg;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits;
    logic               start;
    logic               bit_end;
    logic               clk_fall;
    logic               clk_rise;

    // Gather configuration and accept a load only while idle.
    always_comb begin
        cfg   = '{sync: sync_mode, char7: char7, par_en: par_en, par_odd: par_odd};
        start = tx_load && !busy;
    end

    sertx_frame_build #(.DW(DATA_W)) u_build (
        .cfg   (cfg),
        .data  (tx_data),
        .frame (frame),
        .nbits (nbits)
    );

    sertx_bit_timer #(.TPB(TICKS_PER_BIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (start),
        .run       (busy),
        .baud_tick (baud_tick),
        .bit_end   (bit_end),
        .clk_fall  (clk_fall),
        .clk_rise  (clk_rise)
    );

    sertx_shifter #(.DW(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .sync_in  (sync_mode),
        .frame    (frame),
        .nbits    (nbits),
        .bit_end  (bit_end),
        .clk_fall (clk_fall),
        .clk_rise (clk_rise),
        .txd      (txd),
        .sclk     (sclk),
        .busy     (busy),
        .empty    (empty)
    );

endmodule

// File: rtl/sertx_checker.sv
`timescale 1ns/1ps
// Protocol checker for sertx_top, attached by bind.
// Assumes: synchronous active-low reset held from time zero.
module sertx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_load,
    input logic baud_tick,
    input logic txd,
    input logic sclk,
    input logic busy,
    input logic empty
);

    // R10: idle line and clock stay high.
    a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (txd && sclk));

    // R9: a frame only begins after a load strobe.
    a_r9_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tx_load));

    // R9: empty and busy are always opposite.
    a_r9_empty_vs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy != empty);

    // R2: inside a frame the data line moves only after a baud tick.
    a_r2_txd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(baud_tick)) |-> $stable(txd));

    // R6: serial clock edges follow a baud tick.
    a_r6_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sclk) || $rose(sclk)) |-> $past(baud_tick));

    // R6: data is steady while the serial clock is low.
    a_r6_txd_steady_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk && $past(!sclk)) |-> $stable(txd));

    // R8: a load while busy does not restart or disturb the frame.
    a_r8_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tx_load && !baud_tick) |=> (busy && $stable(txd)));

endmodule

bind sertx_top sertx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_load   (tx_load),
    .baud_tick (baud_tick),
    .txd       (txd),
    .sclk      (sclk),
    .busy      (busy),
    .empty     (empty)
);

// File: tb/sertx_top_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected frames, the monitor checks
// the line bit by bit at the middle of each bit window.
module sertx_top_test;

    localparam int TICK_DIV = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_mode = 1'b0, char7 = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_load = 1'b0;
    logic       baud_tick = 1'b0;
    logic       txd, sclk, busy, empty;

    int total = 0;
    int bad = 0;
    int frames_seen = 0;
    bit all_sent = 1'b0;
    bit finished = 1'b0;
    int div = 0;

    typedef struct {
        logic [10:0] bits;
        int          n;
        bit          sync;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    sertx_top uut (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .char7(char7),
        .par_en(par_en), .par_odd(par_odd), .tx_data(tx_data),
        .tx_load(tx_load), .baud_tick(baud_tick), .txd(txd), .sclk(sclk),
        .busy(busy), .empty(empty)
    );

    // Baud tick generator, driven on the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            div = 0;
            baud_tick = 1'b0;
        end else if (div == TICK_DIV - 1) begin
            div = 0;
            baud_tick = 1'b1;
        end else begin
            div = div + 1;
            baud_tick = 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(input bit s, input bit c7, input bit pe,
                                   input bit po, input logic [7:0] d);
        exp_t e;
        int k = 0;
        int ones = 0;
        e.bits = '1;
        e.sync = s;
        if (s) begin
            for (int i = 0; i < 8; i++) e.bits[i] = d[i];
            e.n = 8;
        end else begin
            e.bits[k] = 1'b0; k = k + 1;
            for (int i = 0; i < (c7 ? 7 : 8); i++) begin
                e.bits[k] = d[i]; k = k + 1;
                ones = ones + int'(d[i]);
            end
            if (pe) begin
                e.bits[k] = po ? ~ones[0] : ones[0]; k = k + 1;
            end
            e.bits[k] = 1'b1; k = k + 1;
            e.n = k;
        end
        return e;
    endfunction

    // Driver: wait for idle, queue the expectation, pulse load.
    task automatic send(input bit s, input bit c7, input bit pe, input bit po,
                        input logic [7:0] d);
        @(negedge clk);
        while (busy) @(negedge clk);
        sync_mode = s; char7 = c7; par_en = pe; par_odd = po; tx_data = d;
        q.push_back(model(s, c7, pe, po, d));
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // R7, R8: disturb config and pulse load in mid-frame.
    task automatic disturb(input logic [7:0] d);
        repeat (40) @(negedge clk);
        sync_mode = ~sync_mode; char7 = ~char7; par_en = ~par_en;
        par_odd = ~par_odd; tx_data = d;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // Monitor: pops expected frames and checks each bit window.
    initial begin
        exp_t e;
        int   n;
        int   last;
        forever begin
            @(posedge clk); #1;
            if (rst_n && busy) begin
                if (q.size() == 0) begin
                    chk("R8", "unexpected frame started", 1, 0);
                    while (busy) begin @(posedge clk); #1; end
                end else begin
                    e = q.pop_front();
                    frames_seen++;
                    chk("R9", "empty low after load", int'(empty), 0);
                    n = 0;
                    last = e.sync ? 16 : 16 * e.n;
                    while (n < last) begin
                        @(posedge clk); #1;
                        if (baud_tick) begin
                            n++;
                            if (n == last) begin
                                chk("R9", "busy low after last bit", int'(busy), 0);
                                chk("R9", "empty high after last bit", int'(empty), 1);
                                chk("R10", "txd idle after frame", int'(txd), 1);
                                chk("R1", "sclk idle after frame", int'(sclk), 1);
                            end else if (e.sync) begin
                                // R5 R6: bit k appears with sclk low at odd tick
                                if (n % 2 == 1) begin
                                    chk("R6", "sclk low on odd tick", int'(sclk), 0);
                                    chk("R5", "sync data bit", int'(txd), int'(e.bits[n / 2]));
                                end else begin
                                    chk("R6", "sclk high on even tick", int'(sclk), 1);
                                    chk("R6", "sync data held", int'(txd), int'(e.bits[(n - 1) / 2]));
                                end
                            end else if (n % 16 == 8) begin
                                chk("R2", "async bit mid-window", int'(txd), int'(e.bits[n / 16]));
                                chk("R9", "busy during frame", int'(busy), 1);
                                chk("R6", "sclk high in async", int'(sclk), 1);
                            end
                        end
                    end
                end
            end
        end
    end

    // Main sequence.
    initial begin
        repeat (4) @(negedge clk);
        chk("R1", "txd reset", int'(txd), 1);
        chk("R1", "sclk reset", int'(sclk), 1);
        chk("R1", "busy reset", int'(busy), 0);
        chk("R1", "empty reset", int'(empty), 1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10", "txd idle before first load", int'(txd), 1);

        // R2: plain 8-bit async frames
        send(0, 0, 0, 0, 8'hA5);
        send(0, 0, 0, 0, 8'h00);
        send(0, 0, 0, 0, 8'hFF);
        // R3: 7-bit frames drop bit 7
        send(0, 1, 0, 0, 8'hD3);
        send(0, 1, 0, 0, 8'h80);
        // R4: even and odd parity
        send(0, 0, 1, 0, 8'h07);
        send(0, 0, 1, 1, 8'h07);
        send(0, 1, 1, 1, 8'hFE);
        send(0, 1, 1, 0, 8'h81);
        // R5: sync ignores async options
        send(1, 1, 1, 1, 8'h81);
        send(1, 0, 0, 0, 8'h3C);
        // R7, R8: mid-frame config change and ignored load
        send(0, 0, 1, 0, 8'h5A);
        disturb(8'hFF);
        send(1, 0, 0, 0, 8'hC6);
        disturb(8'h00);

        @(negedge clk);
        while (busy || q.size() != 0) @(negedge clk);
        repeat (300) @(negedge clk);
        chk("R8", "frames observed", frames_seen, 13);
        chk("R8", "no leftover expectation", q.size(), 0);
        chk("R10", "txd idle at end", int'(txd), 1);
        chk("R10", "busy idle at end", int'(busy), 0);
        all_sent = 1'b1;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule